// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a 14-bit virtual address into a physical address through a small table of four segments. The two most significant address bits select one table entry, and the remaining twelve bits are an offset inside that segment. Every entry records whether it is in use, where the segment starts in physical memory, how long it is, and whether it may be read, written, or both. When the lookup succeeds, the result is the segment start plus the offset. When it fails, the block reports a fault with a cause code and does not produce an address.

A translation is requested with a valid strobe, the virtual address and a read/write flag. The result comes back registered on the following cycle. A separate write port loads one table entry per cycle, for example when the operating system switches between processes. Memory itself is outside this block, and so is any response to a fault.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset every table entry is marked unused, and `rsp_valid`, `rsp_fault`, `rsp_cause` and `rsp_paddr` are all zero.
- R2: Bits [13:12] of `req_vaddr` choose the table entry. Bits [11:0] of `req_vaddr` form the offset.
- R3: For a permitted, in-range access to a used segment, `rsp_paddr` equals the segment base plus the zero-extended offset, modulo 2^16. In that case `rsp_cause` is 0 and `rsp_fault` is 0.
- R4: Any access to an entry whose used flag is 0 reports cause 1.
- R5: An offset greater than or equal to the entry's 13-bit length reports cause 2. A length of 0 therefore rejects every offset, and a length of 0x1000 accepts every offset.
- R6: Bit 0 of the permission field allows reads and bit 1 allows writes (`req_write`=1 means a write). An access of a type that is not allowed reports cause 3.
- R7: When several causes apply, the lowest code wins: an unused entry (1) beats out-of-bounds (2), and out-of-bounds beats a permission violation (3).
- R8: Each result appears on the cycle after the request. `rsp_valid` follows `req_valid` with one cycle of delay. On a cycle with no request, `rsp_cause`, `rsp_fault` and `rsp_paddr` are zero.
- R9: A table write with `tbl_we`=1 takes effect at the clock edge. A translation requested in the same cycle still uses the old entry, and later translations use the new one.
- R10: `rsp_fault` is 1 exactly when `rsp_cause` is nonzero, and `rsp_paddr` is 0 whenever `rsp_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 14 | Virtual address: segment number then offset |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| tbl_we | input | 1 | Table entry write enable |
| tbl_idx | input | 2 | Entry to write |
| tbl_base | input | 16 | Physical start address of the segment |
| tbl_len | input | 13 | Segment length in bytes |
| tbl_perm | input | 2 | Permission bits: bit 0 read, bit 1 write |
| tbl_used | input | 1 | Entry in use |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_paddr | output | 16 | Physical address, zero on a fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 unused segment, 2 out of bounds, 3 permission |

## Verification
Every response is due exactly one rising edge after its request. The bench therefore drives a request on a falling edge and compares the outputs on the next falling edge, so requests can be issued back to back. A table write is applied the same way and affects only requests driven on the following falling edge or later. The same-cycle case is checked by driving a write and a request on the same falling edge and expecting the old entry's result. The sweep covers every offset of every segment, for both reads and writes, against a model the bench holds of the entries it has written.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_UNUSED = 2'd1,
    CAUSE_BOUND  = 2'd2,
    CAUSE_PERM   = 2'd3
  } xl_cause_e;

  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;

  // Lowest code wins when several faults apply.
  function automatic xl_cause_e pick_cause(input logic used,
                                           input logic in_range,
                                           input logic allowed);
    if (!used)          return CAUSE_UNUSED;
    else if (!in_range) return CAUSE_BOUND;
    else if (!allowed)  return CAUSE_PERM;
    else                return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_BITS = 2,
  parameter int PA_BITS  = 16,
  parameter int LEN_BITS = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEG_BITS-1:0] wr_idx,
  input  logic [PA_BITS-1:0]  wr_base,
  input  logic [LEN_BITS-1:0] wr_len,
  input  logic [1:0]          wr_perm,
  input  logic                wr_used,
  input  logic [SEG_BITS-1:0] rd_idx,
  output logic [PA_BITS-1:0]  rd_base,
  output logic [LEN_BITS-1:0] rd_len,
  output logic [1:0]          rd_perm,
  output logic                rd_used
);
  localparam int NSEG = 1 << SEG_BITS;

  logic [PA_BITS-1:0]  base_q [NSEG];
  logic [LEN_BITS-1:0] len_q  [NSEG];
  logic [1:0]          perm_q [NSEG];
  logic [NSEG-1:0]     used_q;

  for (genvar e = 0; e < NSEG; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == SEG_BITS'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[e] <= '0;
        len_q[e]  <= '0;
        perm_q[e] <= '0;
        used_q[e] <= 1'b0;
      end else if (hit) begin
        base_q[e] <= wr_base;
        len_q[e]  <= wr_len;
        perm_q[e] <= wr_perm;
        used_q[e] <= wr_used;
      end
    end
  end

  // Reads see the registered contents: a same-cycle write is not yet visible.
  assign rd_base = base_q[rd_idx];
  assign rd_len  = len_q[rd_idx];
  assign rd_perm = perm_q[rd_idx];
  assign rd_used = used_q[rd_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base_q[$past(wr_idx)] == $past(wr_base)) &&
              (used_q[$past(wr_idx)] == $past(wr_used))); // R9

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16,
  parameter int LEN_BITS = 13
) (
  input  logic [OFF_BITS-1:0] offset,
  input  logic                is_write,
  input  logic [PA_BITS-1:0]  base,
  input  logic [LEN_BITS-1:0] len,
  input  logic [1:0]          perm,
  input  logic                used,
  output logic                in_range,
  output logic                allowed,
  output xl_cause_e           cause,
  output logic [PA_BITS-1:0]  paddr
);

  // Offset is zero-extended; the sum wraps at the physical width.
  function automatic logic [PA_BITS-1:0] calc_paddr(input logic [PA_BITS-1:0] b,
                                                    input logic [OFF_BITS-1:0] o);
    return b + PA_BITS'(o);
  endfunction

  assign in_range = LEN_BITS'(offset) < len;
  assign allowed  = is_write ? perm[PERM_WR] : perm[PERM_RD];
  assign cause    = pick_cause(used, in_range, allowed);
  assign paddr    = calc_paddr(base, offset);

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int SEG_BITS = 2,
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [SEG_BITS+OFF_BITS-1:0] req_vaddr,
  input  logic                         req_write,
  input  logic                         tbl_we,
  input  logic [SEG_BITS-1:0]          tbl_idx,
  input  logic [PA_BITS-1:0]           tbl_base,
  input  logic [OFF_BITS:0]            tbl_len,
  input  logic [1:0]                   tbl_perm,
  input  logic                         tbl_used,
  output logic                         rsp_valid,
  output logic [PA_BITS-1:0]           rsp_paddr,
  output logic                         rsp_fault,
  output logic [1:0]                   rsp_cause
);
  localparam int VA_BITS  = SEG_BITS + OFF_BITS;
  localparam int LEN_BITS = OFF_BITS + 1;

  logic [SEG_BITS-1:0] seg_sel;
  logic [OFF_BITS-1:0] seg_off;
  assign seg_sel = req_vaddr[VA_BITS-1:OFF_BITS];
  assign seg_off = req_vaddr[OFF_BITS-1:0];

  logic [PA_BITS-1:0]  ent_base;
  logic [LEN_BITS-1:0] ent_len;
  logic [1:0]          ent_perm;
  logic                ent_used;

  seg_table #(.SEG_BITS(SEG_BITS), .PA_BITS(PA_BITS), .LEN_BITS(LEN_BITS)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_idx  (tbl_idx),
    .wr_base (tbl_base),
    .wr_len  (tbl_len),
    .wr_perm (tbl_perm),
    .wr_used (tbl_used),
    .rd_idx  (seg_sel),
    .rd_base (ent_base),
    .rd_len  (ent_len),
    .rd_perm (ent_perm),
    .rd_used (ent_used)
  );

  logic               chk_in_range;
  logic               chk_allowed;
  xl_cause_e          chk_cause;
  logic [PA_BITS-1:0] chk_paddr;

  seg_check #(.OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS), .LEN_BITS(LEN_BITS)) u_check (
    .offset   (seg_off),
    .is_write (req_write),
    .base     (ent_base),
    .len      (ent_len),
    .perm     (ent_perm),
    .used     (ent_used),
    .in_range (chk_in_range),
    .allowed  (chk_allowed),
    .cause    (chk_cause),
    .paddr    (chk_paddr)
  );

  logic req_ok;
  logic req_bad;
  assign req_ok  = req_valid && (chk_cause == CAUSE_NONE);
  assign req_bad = req_valid && (chk_cause != CAUSE_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= CAUSE_NONE;
    end else begin
      rsp_valid <= req_valid;
      rsp_paddr <= req_ok ? chk_paddr : '0;
      rsp_fault <= req_bad;
      rsp_cause <= req_valid ? chk_cause : CAUSE_NONE;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_cause == 2'd0) && (rsp_paddr == '0) && !rsp_fault); // R8
  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault == (rsp_cause != 2'd0)); // R10
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0)); // R10
  AST_BOUND_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && chk_cause == CAUSE_BOUND) |-> (ent_used && !chk_in_range)); // R5
  AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && chk_cause == CAUSE_NONE) |-> (ent_used && chk_in_range && chk_allowed)); // R3
  AST_UNUSED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ent_used) |=> (rsp_cause == 2'd1)); // R7

endmodule

// File: tb/seg_xlate_top_tb.sv
module seg_xlate_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_idx = '0;
  logic [15:0] tbl_base = '0;
  logic [12:0] tbl_len = '0;
  logic [1:0]  tbl_perm = '0;
  logic        tbl_used = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;

  int n_checks = 0;
  int n_fail   = 0;

  logic [15:0] m_base [4];
  logic [12:0] m_len  [4];
  logic [1:0]  m_perm [4];
  logic        m_used [4];

  always #10 clk = ~clk;

  seg_xlate_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_base(tbl_base),
    .tbl_len(tbl_len), .tbl_perm(tbl_perm), .tbl_used(tbl_used),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause)
  );

  task automatic check(input string req, input logic [19:0] got, input logic [19:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Model result packed as {valid, fault, cause, paddr}.
  function automatic logic [19:0] model(input int s, input int off, input bit wr);
    int sum;
    bit ok_type;
    if (!m_used[s]) return {1'b1, 1'b1, 2'd1, 16'h0};
    if (off >= int'(m_len[s])) return {1'b1, 1'b1, 2'd2, 16'h0};
    ok_type = wr ? m_perm[s][1] : m_perm[s][0];
    if (!ok_type) return {1'b1, 1'b1, 2'd3, 16'h0};
    sum = (int'(m_base[s]) + off) % 65536;
    return {1'b1, 1'b0, 2'd0, 16'(sum)};
  endfunction

  function automatic string tag_for(input logic [1:0] c);
    case (c)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic load(input int s, input logic [15:0] b, input logic [12:0] l,
                      input logic [1:0] p, input logic u);
    tbl_we = 1'b1; tbl_idx = 2'(s); tbl_base = b; tbl_len = l; tbl_perm = p; tbl_used = u;
    @(posedge clk); @(negedge clk);
    tbl_we = 1'b0;
    m_base[s] = b; m_len[s] = l; m_perm[s] = p; m_used[s] = u;
  endtask

  task automatic xlate(input string req, input int s, input int off, input bit wr);
    logic [19:0] exp;
    exp = model(s, off, wr);
    req_valid = 1'b1; req_vaddr = {2'(s), 12'(off)}; req_write = wr;
    @(posedge clk); @(negedge clk);
    check(req, {rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      m_base[s] = '0; m_len[s] = '0; m_perm[s] = '0; m_used[s] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs quiet after reset
    check("R1", {rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, 20'h0);
    // R1: every entry unused after reset
    for (int s = 0; s < 4; s++) xlate("R1", s, 16, s[0]);

    load(0, 16'h4000, 13'h0700, 2'b01, 1'b1); // code, read only
    load(1, 16'h0000, 13'h0500, 2'b11, 1'b1); // data
    load(2, 16'h0000, 13'h0000, 2'b00, 1'b0); // heap unused
    load(3, 16'h2000, 13'h1000, 2'b11, 1'b1); // stack

    // R2..R6: full sweep, back to back
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4096; o++)
        for (int w = 0; w < 2; w++) begin
          logic [19:0] e;
          e = model(s, o, w[0]);
          xlate(tag_for(e[17:16]), s, o, w[0]);
        end

    // R8: no request, quiet outputs
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8", {rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, 20'h0);

    // R2: spot values at the address split
    xlate("R2", 0, 12'h6FF, 1'b0);
    xlate("R2", 3, 12'hFFF, 1'b1);

    // R7: out of range and wrong type on used entry -> bound wins
    xlate("R7", 0, 12'h800, 1'b1);
    // R7: unused entry with every other fault -> unused wins
    xlate("R7", 2, 12'hFFF, 1'b1);

    // R9: write and request in the same cycle see the old entry
    tbl_we = 1'b1; tbl_idx = 2'd2; tbl_base = 16'h8000; tbl_len = 13'h0010;
    tbl_perm = 2'b01; tbl_used = 1'b1;
    req_valid = 1'b1; req_vaddr = {2'd2, 12'h004}; req_write = 1'b0;
    @(posedge clk); @(negedge clk);
    tbl_we = 1'b0;
    check("R9", {rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, {1'b1, 1'b1, 2'd1, 16'h0});
    m_base[2] = 16'h8000; m_len[2] = 13'h0010; m_perm[2] = 2'b01; m_used[2] = 1'b1;
    xlate("R9", 2, 12'h004, 1'b0);
    check("R9", {rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, {1'b1, 1'b0, 2'd0, 16'h8004});
    xlate("R5", 2, 12'h010, 1'b0);

    // R3: wrap of the sum at 16 bits
    load(2, 16'hFF00, 13'h1000, 2'b11, 1'b1);
    xlate("R3", 2, 12'h200, 1'b0);
    check("R3", {4'b0, rsp_paddr}, {4'b0, 16'h0100});

    // R6: write-only entry
    load(2, 16'h1000, 13'h0100, 2'b10, 1'b1);
    xlate("R6", 2, 12'h010, 1'b0);
    xlate("R6", 2, 12'h010, 1'b1);

    // R5: zero length rejects offset 0
    load(2, 16'h1000, 13'h0000, 2'b11, 1'b1);
    xlate("R5", 2, 0, 1'b0);

    // R10: fault flag tracks cause, address zero on fault
    xlate("R10", 1, 12'hFFF, 1'b0);
    check("R10", {rsp_fault, 3'b0, rsp_paddr}, {1'b1, 3'b0, 16'h0});

    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule